// File: doc/BRIEF.md
# Day and Seconds Real-Time Counter

This block is the counting core of a real-time clock. A one-pulse-per-second tick enable moves a seconds-of-day count forward. That count goes back to zero at the end of each day and carries into a 15-bit count of whole days. Software sees the seconds count through two registers: an 8-bit low byte and a 9-bit high part. The high part moves only when the low byte carries. Because of this, software can write the low byte to zero and then has a window of 255 ticks in which it can rewrite the other fields without being disturbed.

An alarm with the same three-field layout is compared against the running time. The comparison is made only on ticks that advance the count. Two interrupt sources are kept: an alarm match and a once-per-tick update. Each source has a mask bit and a sticky status bit. All access goes through a simple synchronous port with address, write enable, write data and combinational read data. Calendar arithmetic is left to software, and the tick comes from outside the block.

Top module: `dayclock_core`

## Requirements
- R1: Reset clears the day count, both time-of-day fields, the three alarm fields, both mask bits and both status bits, so both request outputs are low.
- R2: Each tick with no time-register write in the same cycle adds one to the seconds-of-day value {high,low}. A tick taken when that value is 86399 or more gives 0 and adds one to the day count.
- R3: The day count is 15 bits wide and is read at address 0 with bits [15:15] returning zero. It wraps from 0x7FFF to 0 on a day carry.
- R4: The register map is: 0 day, 1 time low (8 bits), 2 time high (9 bits), 3 alarm day (15 bits), 4 alarm low (8 bits), 5 alarm high (9 bits), 6 mask, 7 status. Data bits above each field's width are dropped on write and read back as zero.
- R5: The time-high field changes without a write only when the low byte steps from 0xFF, or on a day carry. After the low byte is written to 0, the high field stays unchanged for the next 255 ticks.
- R6: A write to any time register in the same cycle as a tick loads the written value and suppresses that tick's increment. Counting resumes on the following tick.
- R7: Alarm status (status bit 0) is set on a tick that advances the count to a value whose day, low and high all equal the alarm fields. Writing the time registers to a matching value between ticks does not set it.
- R8: Update status (status bit 1) is set on every tick.
- R9: Writing 1 to a status bit at address 7 clears it, and writing 0 leaves it unchanged. If that source's event happens in the same cycle as the clear, the bit stays set.
- R10: The mask register at address 6 holds bit 0 (alarm) and bit 1 (update). Each request output is high exactly when its status bit and its mask bit are both 1.
- R11: With no tick and no write, the day and time-of-day fields hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per elapsed second |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| irq_alarm | output | 1 | Alarm request (status bit 0 AND mask bit 0) |
| irq_update | output | 1 | Update request (status bit 1 AND mask bit 1) |

## Verification
The embedded properties check the following on every cycle:
- the single-step advance and the end-of-day return;
- the rule that the high field moves only on a low-byte carry;
- that the counters hold between ticks;
- that the alarm bit rises only after a tick and only onto a matching time;
- the set and clear behaviour of the status bits.

Some behaviour is visible only in the bench scenarios:
- the 255-tick window after the low byte is cleared;
- bits dropped on write;
- a write that collides with a tick;
- a matching write made between ticks;
- the masking of each request.

The bench's reference model covers each of these.

// File: rtl/dayclock_pkg.sv
package dayclock_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_DAY   = 4'd0,
    RA_TLO   = 4'd1,
    RA_THI   = 4'd2,
    RA_ADAY  = 4'd3,
    RA_ALO   = 4'd4,
    RA_AHI   = 4'd5,
    RA_MASK  = 4'd6,
    RA_STAT  = 4'd7
  } reg_addr_e;

  localparam int NUM_SRC  = 2;
  localparam int SRC_ALRM = 0;
  localparam int SRC_UPD  = 1;

endpackage

// File: rtl/dayclock_tod.sv
module dayclock_tod #(
  parameter int DAY_W = 15,
  parameter int LO_W  = 8,
  parameter int HI_W  = 9,
  parameter int SECS  = 86400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_day,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [DAY_W-1:0] wdata_day,
  input  logic [LO_W-1:0]  wdata_lo,
  input  logic [HI_W-1:0]  wdata_hi,
  output logic [DAY_W-1:0] day_q,
  output logic [LO_W-1:0]  lo_q,
  output logic [HI_W-1:0]  hi_q,
  output logic             step_evt,
  output logic [DAY_W-1:0] nxt_day,
  output logic [LO_W-1:0]  nxt_lo,
  output logic [HI_W-1:0]  nxt_hi
);

  localparam int TOD_W = LO_W + HI_W;
  localparam logic [TOD_W-1:0] LAST_TOD = TOD_W'(SECS - 1);

  // end of day reached (also covers out-of-range programmed values)
  function automatic logic day_end(input logic [HI_W-1:0] h, input logic [LO_W-1:0] l);
    return {h, l} >= LAST_TOD;
  endfunction

  function automatic logic [LO_W-1:0] lo_step(input logic [HI_W-1:0] h, input logic [LO_W-1:0] l);
    return day_end(h, l) ? '0 : l + 1'b1;
  endfunction

  // high part moves only on a low-byte carry or a day wrap
  function automatic logic [HI_W-1:0] hi_step(input logic [HI_W-1:0] h, input logic [LO_W-1:0] l);
    if (day_end(h, l)) return '0;
    else if (&l)       return h + 1'b1;
    else               return h;
  endfunction

  function automatic logic [DAY_W-1:0] day_step(input logic [DAY_W-1:0] d,
                                                input logic [HI_W-1:0] h,
                                                input logic [LO_W-1:0] l);
    return day_end(h, l) ? d + 1'b1 : d;
  endfunction

  logic wr_any;
  logic wrap_now;
  logic lo_carry;

  assign wr_any   = wr_day | wr_lo | wr_hi;
  assign step_evt = tick & ~wr_any;
  assign wrap_now = day_end(hi_q, lo_q);
  assign lo_carry = &lo_q;

  assign nxt_lo  = lo_step(hi_q, lo_q);
  assign nxt_hi  = hi_step(hi_q, lo_q);
  assign nxt_day = day_step(day_q, hi_q, lo_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (step_evt) begin
      day_q <= nxt_day;
      lo_q  <= nxt_lo;
      hi_q  <= nxt_hi;
    end else begin
      if (wr_day) day_q <= wdata_day;
      if (wr_lo)  lo_q  <= wdata_lo;
      if (wr_hi)  hi_q  <= wdata_hi;
    end
  end

  // R2: single step within the day
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !wrap_now) |=> ({hi_q, lo_q} == $past({hi_q, lo_q}) + 1'b1) && $stable(day_q));

  // R2 / R3: end of day returns to zero and carries into the day count
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && wrap_now) |=> ({hi_q, lo_q} == '0) && (day_q == DAY_W'($past(day_q) + 1'b1)));

  // R5: high part changes without a write only on carry or wrap
  p_hi_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_any) && (hi_q != $past(hi_q))) |-> ($past(lo_carry) || $past(wrap_now)));

  // R11: nothing moves without a tick or a write
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_any) |=> $stable(day_q) && $stable(lo_q) && $stable(hi_q));

  // R6: a colliding write wins over the tick
  p_wr_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && wr_lo) |=> lo_q == $past(wdata_lo));

endmodule

// File: rtl/dayclock_alarm.sv
module dayclock_alarm #(
  parameter int DAY_W = 15,
  parameter int LO_W  = 8,
  parameter int HI_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_aday,
  input  logic             wr_alo,
  input  logic             wr_ahi,
  input  logic [DAY_W-1:0] wdata_day,
  input  logic [LO_W-1:0]  wdata_lo,
  input  logic [HI_W-1:0]  wdata_hi,
  input  logic             step_evt,
  input  logic [DAY_W-1:0] cmp_day,
  input  logic [LO_W-1:0]  cmp_lo,
  input  logic [HI_W-1:0]  cmp_hi,
  output logic [DAY_W-1:0] a_day,
  output logic [LO_W-1:0]  a_lo,
  output logic [HI_W-1:0]  a_hi,
  output logic             hit_evt
);

  function automatic logic same_time(input logic [DAY_W-1:0] d0, input logic [HI_W-1:0] h0,
                                     input logic [LO_W-1:0] l0, input logic [DAY_W-1:0] d1,
                                     input logic [HI_W-1:0] h1, input logic [LO_W-1:0] l1);
    return (d0 == d1) && (h0 == h1) && (l0 == l1);
  endfunction

  logic match_nxt;

  assign match_nxt = same_time(cmp_day, cmp_hi, cmp_lo, a_day, a_hi, a_lo);
  // compare only the value a tick is about to load
  assign hit_evt   = step_evt & match_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_day <= '0;
      a_lo  <= '0;
      a_hi  <= '0;
    end else begin
      if (wr_aday) a_day <= wdata_day;
      if (wr_alo)  a_lo  <= wdata_lo;
      if (wr_ahi)  a_hi  <= wdata_hi;
    end
  end

  // R4: alarm fields change only through their own writes
  p_alarm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_aday || wr_alo || wr_ahi) |=> $stable(a_day) && $stable(a_lo) && $stable(a_hi));

endmodule

// File: rtl/dayclock_irq.sv
module dayclock_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            wr_mask,
  input  logic            wr_clr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] irq
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic clr_hit;
    assign clr_hit = wr_clr & wdata[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status[i] <= 1'b0;
        mask[i]   <= 1'b0;
      end else begin
        if (evt[i])       status[i] <= 1'b1;
        else if (clr_hit) status[i] <= 1'b0;
        if (wr_mask)      mask[i]   <= wdata[i];
      end
    end

    assign irq[i] = status[i] & mask[i];

    // R9: write-one clear when no event collides
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !evt[i]) |=> !status[i]);

    // R9: an event beats a clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> status[i]);

    // R9: sticky until cleared
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !clr_hit) |=> status[i]);
  end

endmodule

// File: rtl/dayclock_core.sv
module dayclock_core
  import dayclock_pkg::*;
#(
  parameter int DAY_W  = 15,
  parameter int LO_W   = 8,
  parameter int HI_W   = 9,
  parameter int SECS   = 86400,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_alarm,
  output logic              irq_update
);

  logic wr_day, wr_lo, wr_hi, wr_aday, wr_alo, wr_ahi, wr_mask, wr_clr;

  assign wr_day  = reg_we && (reg_addr == RA_DAY);
  assign wr_lo   = reg_we && (reg_addr == RA_TLO);
  assign wr_hi   = reg_we && (reg_addr == RA_THI);
  assign wr_aday = reg_we && (reg_addr == RA_ADAY);
  assign wr_alo  = reg_we && (reg_addr == RA_ALO);
  assign wr_ahi  = reg_we && (reg_addr == RA_AHI);
  assign wr_mask = reg_we && (reg_addr == RA_MASK);
  assign wr_clr  = reg_we && (reg_addr == RA_STAT);

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  logic [DAY_W-1:0] day_q, nxt_day, a_day;
  logic [LO_W-1:0]  lo_q, nxt_lo, a_lo;
  logic [HI_W-1:0]  hi_q, nxt_hi, a_hi;
  logic             step_evt, hit_evt;
  logic [NUM_SRC-1:0] evt, status, mask, irq;

  dayclock_tod #(.DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W), .SECS(SECS)) u_tod (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1hz),
    .wr_day    (wr_day),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wdata_day (reg_wdata[DAY_W-1:0]),
    .wdata_lo  (reg_wdata[LO_W-1:0]),
    .wdata_hi  (reg_wdata[HI_W-1:0]),
    .day_q     (day_q),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .step_evt  (step_evt),
    .nxt_day   (nxt_day),
    .nxt_lo    (nxt_lo),
    .nxt_hi    (nxt_hi)
  );

  dayclock_alarm #(.DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W)) u_alarm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_aday   (wr_aday),
    .wr_alo    (wr_alo),
    .wr_ahi    (wr_ahi),
    .wdata_day (reg_wdata[DAY_W-1:0]),
    .wdata_lo  (reg_wdata[LO_W-1:0]),
    .wdata_hi  (reg_wdata[HI_W-1:0]),
    .step_evt  (step_evt),
    .cmp_day   (nxt_day),
    .cmp_lo    (nxt_lo),
    .cmp_hi    (nxt_hi),
    .a_day     (a_day),
    .a_lo      (a_lo),
    .a_hi      (a_hi),
    .hit_evt   (hit_evt)
  );

  always_comb begin
    evt           = '0;
    evt[SRC_ALRM] = hit_evt;
    evt[SRC_UPD]  = tick_1hz;
  end

  dayclock_irq #(.NSRC(NUM_SRC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .wr_mask (wr_mask),
    .wr_clr  (wr_clr),
    .wdata   (reg_wdata[NUM_SRC-1:0]),
    .status  (status),
    .mask    (mask),
    .irq     (irq)
  );

  assign irq_alarm  = irq[SRC_ALRM];
  assign irq_update = irq[SRC_UPD];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_DAY:  reg_rdata[DAY_W-1:0]   = day_q;
      RA_TLO:  reg_rdata[LO_W-1:0]    = lo_q;
      RA_THI:  reg_rdata[HI_W-1:0]    = hi_q;
      RA_ADAY: reg_rdata[DAY_W-1:0]   = a_day;
      RA_ALO:  reg_rdata[LO_W-1:0]    = a_lo;
      RA_AHI:  reg_rdata[HI_W-1:0]    = a_hi;
      RA_MASK: reg_rdata[NUM_SRC-1:0] = mask;
      RA_STAT: reg_rdata[NUM_SRC-1:0] = status;
      default: reg_rdata = '0;
    endcase
  end

  // R7: alarm status rises only after a tick
  p_alarm_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SRC_ALRM]) |-> $past(tick_1hz));

  // R7: alarm status rises onto a time equal to the alarm
  p_alarm_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[SRC_ALRM]) && !$past(wr_aday || wr_alo || wr_ahi))
      |-> (day_q == a_day) && (lo_q == a_lo) && (hi_q == a_hi));

  // R8: update status follows every tick
  p_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> status[SRC_UPD]);

  // R10: a request needs its mask bit
  p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[SRC_UPD] |-> !irq_update);

endmodule

// File: tb/dayclock_core_bench.sv
`timescale 1ns/100ps
module dayclock_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_alarm, irq_update;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dayclock_core u_dayclock_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_alarm  (irq_alarm),
    .irq_update (irq_update)
  );

  // behavioural reference model
  int m_day, m_tod, m_aday, m_alo, m_ahi, m_mask, m_st;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_day = 0; m_tod = 0; m_aday = 0; m_alo = 0; m_ahi = 0; m_mask = 0; m_st = 0;
    end else begin
      int ev;
      bit twr;
      ev  = 0;
      twr = reg_we && (reg_addr <= 2);
      if (tick_1hz) ev |= 2;
      if (tick_1hz && !twr) begin
        int nt, nd;
        if (m_tod >= 86399) begin nt = 0; nd = (m_day + 1) % 32768; end
        else begin nt = m_tod + 1; nd = m_day; end
        if (nd == m_aday && nt == m_ahi * 256 + m_alo) ev |= 1;
        m_tod = nt; m_day = nd;
      end
      if (reg_we) begin
        case (reg_addr)
          0: m_day  = reg_wdata & 16'h7FFF;
          1: m_tod  = (m_tod & ~255) | (reg_wdata & 255);
          2: m_tod  = (m_tod & 255) | ((reg_wdata & 511) << 8);
          3: m_aday = reg_wdata & 16'h7FFF;
          4: m_alo  = reg_wdata & 255;
          5: m_ahi  = reg_wdata & 511;
          6: m_mask = reg_wdata & 3;
          7: m_st   = m_st & ~(reg_wdata & 3);
          default: ;
        endcase
      end
      m_st |= ev;
    end
  end

  function automatic int mread(input int a);
    case (a)
      0: return m_day;
      1: return m_tod & 255;
      2: return m_tod >> 8;
      3: return m_aday;
      4: return m_alo;
      5: return m_ahi;
      6: return m_mask;
      7: return m_st;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic compare_model();
    check("R10 model irq_alarm", irq_alarm, (m_st & m_mask) & 1);
    check("R10 model irq_update", irq_update, ((m_st & m_mask) >> 1) & 1);
    check("R4 model rdata", reg_rdata, mread(reg_addr));
  endtask

  // one clock: drive at the falling edge, compare after the rising edge
  task automatic cyc(input bit t, input bit we, input int a, input int d);
    @(negedge clk);
    tick_1hz = t; reg_we = we; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(posedge clk);
    #1;
    compare_model();
    tick_1hz = 1'b0; reg_we = 1'b0;
  endtask

  task automatic wr(input int a, input int d); cyc(0, 1, a, d); endtask
  task automatic tk(); cyc(1, 0, 0, 0); endtask

  task automatic rd(input int a, input int exp, input string req);
    reg_addr = 4'(a);
    #0.1;
    check(req, reg_rdata, exp);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(a, 0, "R1 reset register");
    check("R1 irq_alarm reset", irq_alarm, 0);
    check("R1 irq_update reset", irq_update, 0);

    // R2 counting, R11 hold
    repeat (3) tk();
    rd(1, 3, "R2 three ticks");
    repeat (5) cyc(0, 0, 1, 0);
    rd(1, 3, "R11 hold without tick");

    // R4 dropped bits, R3 day width and wrap
    wr(1, 16'h01FE); rd(1, 8'hFE, "R4 low width");
    wr(2, 16'hFFFF); rd(2, 9'h1FF, "R4 high width");
    wr(0, 16'hFFFF); rd(0, 16'h7FFF, "R3 day width");
    tk();
    rd(0, 0, "R3 day wrap"); rd(1, 0, "R3 low after wrap"); rd(2, 0, "R3 high after wrap");

    // R5 carry and safe window
    wr(2, 5); wr(1, 8'hFF); tk();
    rd(1, 0, "R5 low carry"); rd(2, 6, "R5 high increments on carry");
    wr(1, 0);
    repeat (255) tk();
    rd(2, 6, "R5 high stable 255 ticks"); rd(1, 8'hFF, "R5 low after 255");
    tk();
    rd(2, 7, "R5 high after window");

    // R6 write colliding with tick
    cyc(1, 1, 1, 16'h10);
    rd(1, 16'h10, "R6 write wins"); rd(2, 7, "R6 high untouched");
    tk();
    rd(1, 16'h11, "R6 next tick counts");

    // R2 end of day
    wr(0, 2); wr(2, 16'h151); wr(1, 16'h7E);
    tk(); rd(1, 16'h7F, "R2 last second"); rd(0, 2, "R2 day before carry");
    tk(); rd(1, 0, "R2 day end low"); rd(2, 0, "R2 day end high"); rd(0, 3, "R2 day carry");

    // R7 alarm, R10 masks, R9 clear
    wr(6, 1); wr(3, 3); wr(5, 0); wr(4, 5); wr(7, 3);
    rd(7, 0, "R9 clear both");
    repeat (4) tk();
    rd(7, 2, "R7 no alarm before match");
    check("R7 irq_alarm low", irq_alarm, 0);
    tk();
    rd(7, 3, "R7 alarm on match");
    check("R10 irq_alarm high", irq_alarm, 1);
    check("R10 irq_update masked", irq_update, 0);
    wr(7, 1);
    rd(7, 2, "R9 clear alarm only");
    check("R9 irq_alarm cleared", irq_alarm, 0);
    wr(1, 4); wr(1, 5);
    rd(7, 2, "R7 matching write no alarm");
    check("R7 irq_alarm stays low", irq_alarm, 0);

    // R8 update, R9 set wins
    wr(6, 3);
    check("R10 irq_update unmasked", irq_update, 1);
    wr(7, 2);
    rd(7, 0, "R9 clear update");
    check("R9 irq_update low", irq_update, 0);
    tk();
    rd(7, 2, "R8 update on tick");
    check("R8 irq_update", irq_update, 1);
    cyc(1, 1, 7, 2);
    rd(7, 2, "R9 event beats clear");

    repeat (4) cyc(0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule